// File: doc/BRIEF.md
# Unaligned 128-bit Load Aligner

This block serves 16-byte loads at arbitrary byte addresses from a memory port that can only return whole, 16-byte-aligned lines. A request whose address is already a multiple of 16 costs one line read. Any other request costs two line reads, first the line at the address rounded down to 16 bytes and then the line that follows it. Together those two reads cover a 32-byte window, and a byte shifter picks the 16 wanted bytes out of that window. No single memory access ever crosses a line boundary.

The block takes one request at a time. While a load is in flight the request port is not ready. The result comes back as a one-cycle valid pulse, and the data stays on the response port until the next result replaces it. The memory side may answer each line read after any latency of one cycle or more. Addresses wrap modulo the address width, so a load that starts in the top line of the address space takes its second line from address zero.

Top module: `uload_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_req is 0 and rsp_data is all zeros.
- R2: A request whose address has its low 4 bits equal to zero issues exactly one line read, at that address, and returns that line unchanged.
- R3: A request whose low 4 address bits are nonzero issues exactly two line reads: the first at the address with its low 4 bits cleared (A), the second at A+16. The second read is issued only after the first has been answered.
- R4: For byte offset k (the low 4 address bits), byte i of rsp_data is byte k+i of the 32-byte value {second line, first line}, where byte 0 is bits 7:0 of the first line.
- R5: Each line read is a single-cycle pulse on mem_req, and mem_addr has its low 4 bits at zero whenever mem_req is 1.
- R6: req_ready drops in the cycle after a request is accepted and stays low until the cycle in which rsp_valid is 1. A req_valid seen while req_ready is low is ignored: it issues no read and does not change the result.
- R7: rsp_valid is high for exactly one cycle per request, and rsp_data does not change until the next response.
- R8: The block works for any memory latency of one or more cycles between mem_req and mem_rvalid.
- R9: Line addresses wrap modulo 2^ADDR_W, so for an unaligned request in the highest line the second read is at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_addr | input | ADDR_W | Byte address of the requested 16-byte load |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| mem_addr | output | ADDR_W | Line-aligned read address |
| mem_req | output | 1 | One-cycle line read strobe |
| mem_rvalid | input | 1 | Line read data valid |
| mem_rdata | input | 8*LINE_BYTES | Returned line, byte 0 in bits 7:0 |
| rsp_data | output | 8*LINE_BYTES | Extracted 16 bytes, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | One-cycle result strobe |

## Verification
All 16 byte offsets are swept over several base lines. Offset zero separates the single-read path from the two-read path, and offsets 1 and 15 test the shifter at both ends of its range. The memory model fills each byte with an arithmetic function of its own address, so a wrong line order, a wrong shift amount or a stale line shows up as a byte mismatch. The sweep is repeated with memory latencies of one, two and three cycles, and once more in the top line of the address space to cover wrap-around. Stray requests sent while the block is busy show whether they are really ignored.

// File: rtl/uload_pkg.sv
// Package: shared types for the unaligned load aligner.
// Assumes: nothing beyond IEEE 1800-2017.
package uload_pkg;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ0 = 2'd1,
        ST_READ1 = 2'd2,
        ST_RESP  = 2'd3
    } uload_state_e;

endpackage

// File: rtl/uload_ctrl.sv
// Module: uload_ctrl
// Accepts one load request at a time. It issues one line read, or two for an
// unaligned address, and captures each returned line. It then asks the top
// to register the shifted result.
// Assumes: the memory answers each mem_req pulse with exactly one mem_rvalid
// pulse, at least one cycle later.
module uload_ctrl
    import uload_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 mem_rvalid,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 cap_line0,
    output logic                 cap_line1,
    output logic [$clog2(LINE_BYTES)-1:0] byte_off,
    output logic                 rsp_load
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LIDX_W = ADDR_W - OFF_W;

    uload_state_e              state;
    logic                      issued;
    logic [LIDX_W-1:0]         line_idx;
    logic [OFF_W-1:0]          off_q;
    logic [LIDX_W-1:0]         cur_idx;
    logic                      in_read;

    // Step through the states and remember the request being served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            issued   <= 1'b0;
            line_idx <= '0;
            off_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        line_idx <= req_addr[ADDR_W-1:OFF_W];
                        off_q    <= req_addr[OFF_W-1:0];
                        issued   <= 1'b0;
                        state    <= ST_READ0;
                    end
                end
                ST_READ0: begin
                    if (!issued) begin
                        issued <= 1'b1;
                    end else if (mem_rvalid) begin
                        issued <= 1'b0;
                        state  <= (off_q == '0) ? ST_RESP : ST_READ1;
                    end
                end
                ST_READ1: begin
                    if (!issued) begin
                        issued <= 1'b1;
                    end else if (mem_rvalid) begin
                        issued <= 1'b0;
                        state  <= ST_RESP;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Work out the line index for the current read; it wraps past the top.
    always_comb begin
        cur_idx = (state == ST_READ1) ? line_idx + LIDX_W'(1) : line_idx;
    end

    // Drive the handshakes and strobes from the current state.
    always_comb begin
        in_read   = (state == ST_READ0) || (state == ST_READ1);
        req_ready = (state == ST_IDLE);
        mem_req   = in_read && !issued;
        mem_addr  = {cur_idx, {OFF_W{1'b0}}};
        cap_line0 = (state == ST_READ0) && issued && mem_rvalid;
        cap_line1 = (state == ST_READ1) && issued && mem_rvalid;
        rsp_load  = (state == ST_RESP);
        byte_off  = off_q;
    end

endmodule

// File: rtl/uload_linebuf.sv
// Module: uload_linebuf
// Holds the fetched lines of the aligned window, one register per line.
// Each line register loads when its capture strobe is high.
// Assumes: at most one capture strobe is high in any cycle.
module uload_linebuf #(
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_LINES-1:0]               cap,
    input  logic [8*LINE_BYTES-1:0]            line_in,
    output logic [NUM_LINES*8*LINE_BYTES-1:0]  window
);

    localparam int DATA_W = 8 * LINE_BYTES;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [DATA_W-1:0] line_q;

        // Load this line register when its read returns.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q <= '0;
            end else if (cap[g]) begin
                line_q <= line_in;
            end
        end

        assign window[g*DATA_W +: DATA_W] = line_q;
    end

endmodule

// File: rtl/uload_shift.sv
// Module: uload_shift
// Byte shifter: output byte i is byte (off + i) of a two-line window.
// Byte 0 sits in the least significant bits.
// Assumes: off is less than LINE_BYTES; purely combinational.
module uload_shift #(
    parameter int LINE_BYTES = 16
) (
    input  logic [2*8*LINE_BYTES-1:0]      window,
    input  logic [$clog2(LINE_BYTES)-1:0]  off,
    output logic [8*LINE_BYTES-1:0]        dout
);

    localparam int OFF_W = $clog2(LINE_BYTES);

    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
        logic [OFF_W:0] src;

        // Select the window byte that lands in output byte i.
        always_comb begin
            src = {1'b0, off} + (OFF_W+1)'(i);
            dout[i*8 +: 8] = window[int'(src)*8 +: 8];
        end
    end

endmodule

// File: rtl/uload_top.sv
// Module: uload_top
// Unaligned load aligner. It serves a 16-byte load at any byte address using
// aligned line reads only. It reads one line for an aligned address, or two
// consecutive lines otherwise, and shifts the wanted bytes into place.
// Assumes: single outstanding request; memory answers every read once after
// one or more cycles.
module uload_top #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_valid,
    output logic                    req_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_req,
    input  logic                    mem_rvalid,
    input  logic [8*LINE_BYTES-1:0] mem_rdata,
    output logic [8*LINE_BYTES-1:0] rsp_data,
    output logic                    rsp_valid
);

    localparam int DATA_W = 8 * LINE_BYTES;
    localparam int OFF_W  = $clog2(LINE_BYTES);

    logic              cap_line0;
    logic              cap_line1;
    logic [OFF_W-1:0]  byte_off;
    logic              rsp_load;
    logic [2*DATA_W-1:0] window;
    logic [DATA_W-1:0] shifted;

    uload_ctrl #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_addr   (req_addr),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .cap_line0  (cap_line0),
        .cap_line1  (cap_line1),
        .byte_off   (byte_off),
        .rsp_load   (rsp_load)
    );

    uload_linebuf #(
        .LINE_BYTES (LINE_BYTES),
        .NUM_LINES  (2)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     ({cap_line1, cap_line0}),
        .line_in (mem_rdata),
        .window  (window)
    );

    uload_shift #(
        .LINE_BYTES (LINE_BYTES)
    ) u_shift (
        .window (window),
        .off    (byte_off),
        .dout   (shifted)
    );

    // Register the result and raise a one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data  <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= rsp_load;
            if (rsp_load) begin
                rsp_data <= shifted;
            end
        end
    end

endmodule

// File: rtl/uload_chk.sv
// Module: uload_chk
// Protocol checker for uload_top, attached with bind below.
// Assumes: the same parameters as the instance it watches.
module uload_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic                    mem_req,
    input logic [8*LINE_BYTES-1:0] rsp_data,
    input logic                    rsp_valid
);

    localparam int OFF_W = $clog2(LINE_BYTES);

    logic [1:0]        rd_cnt;
    logic [ADDR_W-1:0] prev_addr;

    // Count line reads since the last accepted request and keep the last address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt    <= '0;
            prev_addr <= '0;
        end else if (req_valid && req_ready) begin
            rd_cnt <= '0;
        end else if (mem_req) begin
            prev_addr <= mem_addr;
            if (rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
        end
    end

    // R5
    line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R3
    max_two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (rd_cnt < 2'd2));

    // R3
    second_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && rd_cnt == 2'd1) |-> (mem_addr == prev_addr + ADDR_W'(LINE_BYTES)));

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    no_read_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    // R7
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(rsp_data));

endmodule

bind uload_top uload_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_req   (mem_req),
    .rsp_data  (rsp_data),
    .rsp_valid (rsp_valid)
);

// File: tb/sim_uload_top.sv
module sim_uload_top;

    localparam int AW = 32;
    localparam int LB = 16;
    localparam int DW = 8 * LB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] mem_addr;
    logic          mem_req;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] rsp_data;
    logic          rsp_valid;

    int total = 0;
    int bad = 0;

    // Memory model state.
    int            lat = 1;
    int            cnt = 0;
    logic [AW-1:0] pend_addr = '0;
    int            nreads = 0;
    logic [AW-1:0] rd_addr [2];
    logic          prev_req = 1'b0;
    int            pulse_err = 0;

    uload_top #(.ADDR_W(AW), .LINE_BYTES(LB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_valid(req_valid),
        .req_ready(req_ready), .mem_addr(mem_addr), .mem_req(mem_req),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_data(rsp_data), .rsp_valid(rsp_valid)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
        logic [7:0] m;
        m = 8'(a[7:0] * 8'd29);
        return m ^ a[15:8] ^ a[31:24] ^ 8'h3C;
    endfunction

    function automatic logic [DW-1:0] mline(input logic [AW-1:0] a);
        logic [DW-1:0] d;
        for (int b = 0; b < LB; b++) d[b*8 +: 8] = mbyte(a + AW'(b));
        return d;
    endfunction

    // Memory model: answers each read after lat cycles, logs addresses.
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mline(pend_addr);
            end
        end
        if (mem_req && prev_req) pulse_err++;
        prev_req = mem_req;
        if (mem_req) begin
            if (nreads < 2) rd_addr[nreads] = mem_addr;
            nreads++;
            pend_addr = mem_addr;
            cnt = lat;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_load(input logic [AW-1:0] a, input bit stray);
        logic [DW-1:0] exp;
        logic [AW-1:0] base;
        int            off;
        int            waitn;
        bit            busy_ok;
        off  = int'(a[3:0]);
        base = {a[AW-1:4], 4'h0};
        for (int i = 0; i < LB; i++) exp[i*8 +: 8] = mbyte(a + AW'(i));
        nreads = 0;
        pulse_err = 0;
        @(negedge clk);
        req_addr  = a;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        busy_ok = (req_ready == 1'b0);
        if (stray) req_addr = a ^ 32'h0000_1235;
        else req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        waitn = 0;
        while (!rsp_valid && waitn < 60) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            waitn++;
        end
        // R6: busy until the response cycle, and ready returns with it
        chk(busy_ok && req_ready, "R6", "ready while busy", DW'(req_ready), DW'(1));
        // R4 / R2 / R9 / R8: extracted data
        chk(rsp_valid && rsp_data == exp, off == 0 ? "R2" : "R4", "data", rsp_data, exp);
        // R3 / R2: read count and addresses
        if (off == 0) begin
            chk(nreads == 1 && rd_addr[0] == base, "R2", "one read",
                DW'(nreads), DW'(1));
        end else begin
            chk(nreads == 2 && rd_addr[0] == base && rd_addr[1] == base + 32'd16,
                "R3", "two reads A then A+16", DW'(rd_addr[1]), DW'(base + 32'd16));
        end
        // R5: single-cycle read strobes
        chk(pulse_err == 0, "R5", "mem_req pulse", DW'(pulse_err), DW'(0));
        @(negedge clk);
        // R7: single-cycle valid, data held
        chk(!rsp_valid && rsp_data == exp, "R7", "valid pulse and hold", rsp_data, exp);
        repeat (2) @(negedge clk);
        chk(rsp_data == exp, "R7", "hold later", rsp_data, exp);
        // R6: stray request gave no extra read
        if (stray) chk(nreads == (off == 0 ? 1 : 2), "R6", "stray ignored",
                       DW'(nreads), DW'(off == 0 ? 1 : 2));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0 && rsp_data == '0,
            "R1", "reset state", rsp_data, '0);
        rst_n = 1'b1;
        // R8: sweep with latencies 1..3
        for (int l = 1; l <= 3; l++) begin
            lat = l;
            for (int o = 0; o < LB; o++) begin
                do_load(32'h0001_2340 + AW'(l * 48) + AW'(o), (o % 5) == 2);
            end
        end
        // R9: top line wraps to address 0
        lat = 2;
        for (int o = 0; o < LB; o++) do_load(32'hFFFF_FFF0 + AW'(o), 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule